// File: doc/BRIEF.md
# Function-Relative Next-PC Unit

This block decides where a 16-bit fixed-width instruction machine executes next. Execution is located by a pair of registers: a function index that selects the current function and a program counter that counts whole instructions from zero at that function's first instruction. Every cycle that carries a valid instruction, the block picks one of four outcomes:

- advance to the next instruction;
- take a relative branch guarded by a predicate bit;
- enter a new function named by a pointer register;
- expose the hidden pair so it can be copied into two pointer registers.

Because the program counter steps by one instruction rather than by bytes, no target can fall inside an instruction. Every new program counter inside the current function is checked against that function's length, which the surrounding pipeline supplies from its function table. A target below zero or at or past the length raises a one-cycle fault, and the pair is left unchanged. The predicate bits and the eight pointer registers come in as flat vectors. The short branch form also hands its pointer register out as a side operand.

Top module: `fn_branch_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first valid instruction, the function index and program counter read 0 and the fault flag reads 0.
- R2: In a cycle with instr_valid low, the function index and program counter keep their values and no fault is reported after the next clock edge.
- R3: A valid instruction outside the branch, call and pair-read classes moves the program counter to its value plus one after the next clock edge.
- R4: Long branch: bits 6:3 equal 1111, bits 2:0 name predicate bit b0..b7 of pred_bits, and bits 15:7 are a two's complement offset (range -256..+255). If the named predicate is 1 the program counter becomes PC plus offset; if it is 0 it becomes PC plus one. An offset of all ones returns to the instruction just before the branch.
- R5: Short branch: bits 6:3 equal 1110, bits 2:0 name the predicate, bits 15:10 are a two's complement offset (-32..+31) and bits 9:7 name a pointer register. It moves the program counter the same way as R4. In the same cycle side_valid is 1 and side_ptr carries that pointer register, and side_valid is 0 for every other instruction.
- R6: Call: opcode bits 6:0 equal 7'h05, and bits 9:7 name a pointer register. After the edge the function index equals that register's 16-bit value, the program counter is 0 and no fault is reported.
- R7: Pair read: opcode bits 6:0 equal 7'h06. In the same cycle pair_valid is 1, pair_fi_dst is bits 9:7, pair_pc_dst is bits 12:10, and pair_fi_val and pair_pc_val carry the current function index and program counter. The program counter then advances by one.
- R8: If the new program counter from R3, R4, R5 or R7 is negative or not below fn_len, fault is 1 for the one cycle after the edge and the function index and program counter keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| pred_bits | input | 8 | Predicate bits b0..b7, bit k is bk |
| ptr_regs | input | 128 | Pointer registers, register k at bits 16k+15:16k |
| fn_len | input | 16 | Length in instructions of the current function |
| fi | output | 16 | Current function index |
| pc | output | 16 | Current function-relative program counter |
| fault | output | 1 | Out-of-range target seen on the previous edge |
| side_valid | output | 1 | Short branch presents its pointer operand |
| side_ptr | output | 16 | Pointer register named by a short branch |
| pair_valid | output | 1 | Pair-read instruction present |
| pair_fi_dst | output | 3 | Pointer register to receive the function index |
| pair_pc_dst | output | 3 | Pointer register to receive the program counter |
| pair_fi_val | output | 16 | Function index to be written |
| pair_pc_val | output | 16 | Program counter to be written |

## Verification
Branches are tried with the named predicate both set and clear, including masks where only the named bit is set, which shows whether the right predicate index is decoded. Offsets cover positive and negative values and the extremes of both widths (+255, -256, -255, -32, -1). These show whether sign extension and field placement are right for each format. Targets are placed at -1, at fn_len and at fn_len-1, and the program counter is also made to step off the end sequentially, which separates a correct bound from one that is off by one. Calls, pair reads and idle cycles are mixed in to show that only the right class touches the function index and the side outputs.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 7;
    localparam int IDX_W   = 3;
    localparam int NREG    = 1 << IDX_W;
    localparam int LOFF_W  = 9;
    localparam int SOFF_W  = 6;

    localparam logic [OPC_W-1:0] OPC_CALL  = 7'h05;
    localparam logic [OPC_W-1:0] OPC_PAIR  = 7'h06;
    localparam logic [3:0]       TAG_LONG  = 4'b1111;
    localparam logic [3:0]       TAG_SHORT = 4'b1110;

    typedef enum logic [2:0] {
        K_SEQ,
        K_BLONG,
        K_BSHORT,
        K_CALL,
        K_PAIR
    } kind_e;

endpackage

// File: rtl/fbu_decode.sv
module fbu_decode
    import fbu_pkg::*;
#(
    parameter int EXT_W = 18
) (
    input  logic [INSTR_W-1:0]    instr,
    output kind_e                 kind,
    output logic [IDX_W-1:0]      pred_idx,
    output logic [IDX_W-1:0]      ptr_idx,
    output logic [IDX_W-1:0]      pc_dst_idx,
    output logic signed [EXT_W-1:0] offset
);

    logic [3:0] tag;
    assign tag = instr[6:3];

    always_comb begin
        if (tag == TAG_LONG)             kind = K_BLONG;
        else if (tag == TAG_SHORT)       kind = K_BSHORT;
        else if (instr[6:0] == OPC_CALL) kind = K_CALL;
        else if (instr[6:0] == OPC_PAIR) kind = K_PAIR;
        else                             kind = K_SEQ;
    end

    assign pred_idx   = instr[2:0];
    assign ptr_idx    = instr[9:7];
    assign pc_dst_idx = instr[12:10];

    always_comb begin
        if (kind == K_BLONG)
            offset = {{(EXT_W-LOFF_W){instr[15]}}, instr[15:7]};
        else
            offset = {{(EXT_W-SOFF_W){instr[15]}}, instr[15:10]};
    end

endmodule

// File: rtl/fbu_opsel.sv
module fbu_opsel
    import fbu_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic [NREG-1:0]       pred_bits,
    input  logic [NREG*PTR_W-1:0] ptr_regs,
    input  logic [IDX_W-1:0]      pred_idx,
    input  logic [IDX_W-1:0]      ptr_idx,
    output logic                  pred_bit,
    output logic [PTR_W-1:0]      ptr_val
);

    logic [PTR_W-1:0] ptr_arr [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_unpack
        assign ptr_arr[k] = ptr_regs[k*PTR_W +: PTR_W];
    end

    assign pred_bit = pred_bits[pred_idx];
    assign ptr_val  = ptr_arr[ptr_idx];

endmodule

// File: rtl/fbu_target.sv
module fbu_target #(
    parameter int PC_W  = 16,
    parameter int EXT_W = PC_W + 2
) (
    input  logic [PC_W-1:0]         pc_cur,
    input  logic signed [EXT_W-1:0] offset,
    input  logic                    use_off,
    input  logic [PC_W-1:0]         fn_len,
    output logic [PC_W-1:0]         target,
    output logic                    out_of_range
);

    logic signed [EXT_W-1:0] pc_ext;
    logic signed [EXT_W-1:0] step;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] len_ext;

    assign pc_ext  = $signed({{(EXT_W-PC_W){1'b0}}, pc_cur});
    assign len_ext = $signed({{(EXT_W-PC_W){1'b0}}, fn_len});
    assign step    = use_off ? offset : EXT_W'(1);
    assign sum     = pc_ext + step;

    assign target       = sum[PC_W-1:0];
    assign out_of_range = sum[EXT_W-1] || (sum >= len_ext);

endmodule

// File: rtl/fn_branch_unit.sv
module fn_branch_unit
    import fbu_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int PC_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [INSTR_W-1:0]    instr,
    input  logic [NREG-1:0]       pred_bits,
    input  logic [NREG*PTR_W-1:0] ptr_regs,
    input  logic [PC_W-1:0]       fn_len,
    output logic [PTR_W-1:0]      fi,
    output logic [PC_W-1:0]       pc,
    output logic                  fault,
    output logic                  side_valid,
    output logic [PTR_W-1:0]      side_ptr,
    output logic                  pair_valid,
    output logic [IDX_W-1:0]      pair_fi_dst,
    output logic [IDX_W-1:0]      pair_pc_dst,
    output logic [PTR_W-1:0]      pair_fi_val,
    output logic [PTR_W-1:0]      pair_pc_val
);

    localparam int EXT_W = PC_W + 2;

    typedef struct packed {
        logic [PTR_W-1:0] fi;
        logic [PC_W-1:0]  pc;
        logic             fault;
    } state_t;

    state_t st_q, st_d;

    kind_e                   kind;
    logic [IDX_W-1:0]        pred_idx, ptr_idx, pc_dst_idx;
    logic signed [EXT_W-1:0] offset;
    logic                    pred_bit;
    logic [PTR_W-1:0]        ptr_val;
    logic                    use_off;
    logic [PC_W-1:0]         target;
    logic                    oor;

    fbu_decode #(.EXT_W(EXT_W)) u_dec (
        .instr      (instr),
        .kind       (kind),
        .pred_idx   (pred_idx),
        .ptr_idx    (ptr_idx),
        .pc_dst_idx (pc_dst_idx),
        .offset     (offset)
    );

    fbu_opsel #(.PTR_W(PTR_W)) u_sel (
        .pred_bits (pred_bits),
        .ptr_regs  (ptr_regs),
        .pred_idx  (pred_idx),
        .ptr_idx   (ptr_idx),
        .pred_bit  (pred_bit),
        .ptr_val   (ptr_val)
    );

    assign use_off = instr_valid && pred_bit &&
                     (kind == K_BLONG || kind == K_BSHORT);

    fbu_target #(.PC_W(PC_W), .EXT_W(EXT_W)) u_tgt (
        .pc_cur       (st_q.pc),
        .offset       (offset),
        .use_off      (use_off),
        .fn_len       (fn_len),
        .target       (target),
        .out_of_range (oor)
    );

    always_comb begin
        logic bound;
        st_d       = st_q;
        st_d.fault = 1'b0;
        bound      = 1'b0;
        if (instr_valid) begin
            unique case (kind)
                K_CALL: begin
                    st_d.fi = ptr_val;
                    st_d.pc = '0;
                end
                default: bound = 1'b1;
            endcase
        end
        if (bound) begin
            if (oor) st_d.fault = 1'b1;
            else     st_d.pc    = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fi          = st_q.fi;
    assign pc          = st_q.pc;
    assign fault       = st_q.fault;
    assign side_valid  = instr_valid && (kind == K_BSHORT);
    assign side_ptr    = ptr_val;
    assign pair_valid  = instr_valid && (kind == K_PAIR);
    assign pair_fi_dst = ptr_idx;
    assign pair_pc_dst = pc_dst_idx;
    assign pair_fi_val = st_q.fi;
    assign pair_pc_val = PTR_W'(st_q.pc);

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (pc == $past(pc) && fi == $past(fi)));

    // R6
    call_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && kind == K_CALL) |=> (pc == '0 && !fault));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(pc) && $stable(fi) && !fault));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && kind == K_SEQ && !oor) |=> (pc == $past(pc) + PC_W'(1)));

    // R5
    side_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(side_valid && pair_valid));

endmodule

// File: tb/fn_branch_unit_test.sv
module fn_branch_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [15:0]  instr = '0;
    logic [7:0]   pred_bits = '0;
    logic [127:0] ptr_regs;
    logic [15:0]  fn_len = 16'd40;
    logic [15:0]  fi, pc, side_ptr, pair_fi_val, pair_pc_val;
    logic         fault, side_valid, pair_valid;
    logic [2:0]   pair_fi_dst, pair_pc_dst;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    int m_fi = 0, m_pc = 0, m_fault = 0;

    always #5 clk = ~clk;

    fn_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pred_bits(pred_bits), .ptr_regs(ptr_regs), .fn_len(fn_len),
        .fi(fi), .pc(pc), .fault(fault), .side_valid(side_valid),
        .side_ptr(side_ptr), .pair_valid(pair_valid), .pair_fi_dst(pair_fi_dst),
        .pair_pc_dst(pair_pc_dst), .pair_fi_val(pair_fi_val), .pair_pc_val(pair_pc_val)
    );

    function automatic int ptr_of(input int k);
        return 16'h1000 + k * 16'h0111;
    endfunction

    initial begin
        for (int k = 0; k < 8; k++) ptr_regs[k*16 +: 16] = 16'(ptr_of(k));
    end

    function automatic logic [15:0] enc_long(input int off, input int p);
        logic [8:0] o = 9'(off);
        return {o, 4'b1111, 3'(p)};
    endfunction

    function automatic logic [15:0] enc_short(input int off, input int r, input int p);
        logic [5:0] o = 6'(off);
        return {o, 3'(r), 4'b1110, 3'(p)};
    endfunction

    function automatic logic [15:0] enc_call(input int r);
        return {6'b0, 3'(r), 7'h05};
    endfunction

    function automatic logic [15:0] enc_pair(input int fd, input int pd);
        return {3'b0, 3'(pd), 3'(fd), 7'h06};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
            $finish;
        end
    endtask

    // Drive one cycle at a falling edge, check same-cycle outputs, then the state after the edge.
    task automatic step(input logic v, input logic [15:0] ins, input logic [7:0] pr,
                        input int len, input string tag);
        int off, tgt, cls;
        instr_valid = v; instr = ins; pred_bits = pr; fn_len = 16'(len);
        #1;
        // same-cycle side and pair outputs (R5, R7)
        chk({tag, " side_valid R5"}, side_valid, (v && ins[6:3] == 4'b1110) ? 1 : 0);
        if (v && ins[6:3] == 4'b1110)
            chk({tag, " side_ptr R5"}, side_ptr, ptr_of(ins[9:7]));
        chk({tag, " pair_valid R7"}, pair_valid,
            (v && ins[6:3] != 4'b1110 && ins[6:3] != 4'b1111 && ins[6:0] == 7'h06) ? 1 : 0);
        if (v && ins[6:0] == 7'h06) begin
            chk({tag, " pair_fi_val R7"}, pair_fi_val, m_fi);
            chk({tag, " pair_pc_val R7"}, pair_pc_val, m_pc);
            chk({tag, " pair_fi_dst R7"}, pair_fi_dst, ins[9:7]);
            chk({tag, " pair_pc_dst R7"}, pair_pc_dst, ins[12:10]);
        end
        // reference model for the next state
        m_fault = 0;
        if (v) begin
            cls = (ins[6:3] == 4'b1111) ? 1 : (ins[6:3] == 4'b1110) ? 2 :
                  (ins[6:0] == 7'h05) ? 3 : 0;
            if (cls == 3) begin
                m_fi = ptr_of(ins[9:7]);
                m_pc = 0;
            end else begin
                tgt = m_pc + 1;
                if (cls == 1 && pr[ins[2:0]]) begin
                    off = ins[15:7]; if (off >= 256) off -= 512;
                    tgt = m_pc + off;
                end else if (cls == 2 && pr[ins[2:0]]) begin
                    off = ins[15:10]; if (off >= 32) off -= 64;
                    tgt = m_pc + off;
                end
                if (tgt < 0 || tgt >= len) m_fault = 1;
                else m_pc = tgt;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " pc"}, pc, m_pc);
        chk({tag, " fi"}, fi, m_fi);
        chk({tag, " fault"}, fault, m_fault);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", pc, 0);
        chk("R1 reset fi", fi, 0);
        chk("R1 reset fault", fault, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release pc", pc, 0);
        chk("R1 after release fault", fault, 0);

        step(0, enc_long(5, 0), 8'hFF, 40, "R2 idle");
        step(1, 16'h0001, 8'h00, 40, "R3 seq a");
        step(1, 16'h0001, 8'h00, 40, "R3 seq b");
        step(1, 16'h0042, 8'hFF, 40, "R3 seq c");
        step(1, enc_long(10, 2), 8'b0000_0100, 40, "R4 long taken");
        step(1, enc_long(10, 2), 8'b1111_1011, 40, "R4 long not taken");
        step(1, enc_long(-1, 0), 8'b0000_0001, 40, "R4 offset minus one");
        step(1, enc_long(3, 5), 8'b0010_0000, 40, "R4 only b5 set");
        step(1, enc_short(5, 6, 7), 8'b1000_0000, 40, "R5 short taken");
        step(1, enc_short(-8, 2, 7), 8'b0111_1111, 40, "R5 short not taken");
        step(1, enc_short(-32, 1, 3), 8'b0000_1000, 40, "R8 short below zero");
        step(1, enc_pair(1, 4), 8'h00, 40, "R7 pair read");
        step(0, 16'h0001, 8'h00, 40, "R2 idle after pair");
        step(1, enc_long(25, 1), 8'b0000_0010, 40, "R8 long past end");
        step(1, enc_long(40 - m_pc, 1), 8'b0000_0010, 40, "R8 target equals len");
        step(1, enc_long(39 - m_pc, 1), 8'b0000_0010, 40, "R4 target len minus one");
        step(1, 16'h0001, 8'h00, 40, "R8 seq off end");
        step(1, enc_short(-3, 0, 4), 8'b0001_0000, 40, "R5 short back");
        step(1, enc_call(3), 8'h00, 40, "R6 call");
        step(1, enc_long(255, 6), 8'b0100_0000, 300, "R4 max forward");
        step(1, enc_long(-256, 6), 8'b0100_0000, 300, "R8 min offset below zero");
        step(1, enc_long(-255, 6), 8'b0100_0000, 300, "R4 back to zero");
        step(1, enc_pair(7, 0), 8'h00, 300, "R7 pair after call");
        step(1, enc_call(7), 8'hFF, 1, "R6 call second");
        step(1, 16'h0001, 8'h00, 1, "R8 len one seq");
        step(0, 16'h0000, 8'h00, 1, "R2 idle end");

        finish_run();
    end

endmodule